// File: doc/BRIEF.md
# Flash Command Decoder and Status Register

This block sits between a synchronous bus and the program/erase machinery of a NOR-style flash array. Every bus write carries a command byte in the low eight data bits. Single-cycle commands choose what later reads return: array data, identifier words, query words or the status register. Two-cycle commands start a block erase, a full chip erase, a word program, a one-time-program write or a lock change. The block checks the second cycle and then hands the operation to an engine through a one-cycle start pulse that carries a kind code, an address and a data word.

Inside the block, the engine is modelled as a busy counter. Its length is taken from an input when the operation is dispatched. An error-inject input, also sampled at dispatch, makes the operation fail when it completes. Block erase and word program can be paused with a suspend command and continued with a resume command. An external allow flag stands in for the lock state of the addressed block.

The 8-bit status register reports the following: ready/busy, the two suspend states, erase and program failures, attempts on locked blocks, and malformed command sequences.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, mode_o is 0 (array), status_o is 80h and busy_o is 0. Asserting rst_ni during a running or suspended operation aborts it.
- R2: A write of FFh sets mode_o to 0. A write of 90h sets it to 1 (identifier). A write of 98h sets it to 2 (query). A write of 70h sets it to 3 (status). An unlisted opcode written while idle changes nothing.
- R3: The following sequences dispatch an operation: 20h then D0h (block erase, kind 0); 30h then D0h (chip erase, kind 1); 40h or 10h then the data word (program, kind 2); C0h then the data word (OTP program, kind 3). On the edge of the second write, op_start_o pulses for one cycle with op_kind_o, op_addr_o and op_data_o set. The first write selects mode 3.
- R4: busy_o is high for max(busy_len_i,1) cycles, starting with the cycle after the dispatching write. status_o[7] is 1 exactly when busy_o is 0.
- R5: If the second write of a two-cycle command has an address different from the first, or (for erase) a code other than D0h, bits 5 and 4 are set, nothing is dispatched, and the decoder returns to idle.
- R6: Bits 5, 4 and 1 stay set until a 50h write clears them. A 50h write leaves bits 6 and 2 alone, and a later successful operation does not clear the error bits.
- R7: If allow_i is 0 on the second write of a block erase, status bits 1 and 5 are set and nothing is dispatched. If allow_i is 0 on the second write of a word program, bits 1 and 4 are set and nothing is dispatched. Chip erase, OTP program and lock commands ignore allow_i.
- R8: If err_inject_i is 1 at dispatch, the operation sets bit 5 (kinds 0 and 1) or bit 4 (kinds 2 and 3) on the edge where busy_o falls.
- R9: B0h written during a block erase, or during a word program that is not nested under a suspended erase, drops busy_o on the next cycle and sets bit 6 (erase) or bit 2 (program). D0h written while idle and suspended resumes the operation. The busy cycles before and after the suspension add up to the programmed length.
- R10: B0h written during a chip erase, an OTP program, or a program nested under a suspended erase is ignored.
- R11: While an operation is suspended, 20h, 30h and C0h set bits 5 and 4. 40h/10h are accepted only when the suspended operation is an erase.
- R12: The first write 60h followed by 01h, D0h or 2Fh at the same address dispatches kind 4 (lock), 5 (unlock) or 6 (lock-down) without raising busy_o. Any other second code sets bits 5 and 4.
- R13: While busy_o is 1, mode_o reads 3 and status_o reads 00h, and every write other than a valid suspend is ignored. Bits 3 and 0 of status_o are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | AW | Write address |
| wdata_i | input | DW | Write data; bits 7:0 carry the command byte |
| allow_i | input | 1 | Addressed block may be erased or programmed |
| err_inject_i | input | 1 | Make the operation being dispatched fail |
| busy_len_i | input | CW | Busy length in cycles for the operation being dispatched |
| mode_o | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |
| status_o | output | 8 | Status register |
| busy_o | output | 1 | Operation in progress |
| op_start_o | output | 1 | One-cycle dispatch pulse |
| op_kind_o | output | 3 | Kind of the current or last operation |
| op_addr_o | output | AW | Address of the operation |
| op_data_o | output | DW | Program data of the operation |

## Verification
The assertions watch invariants that hold on every cycle. A busy block reads as status with its flag bits masked. Reserved bits stay zero, at most one suspend flag is ever set, and the dispatch pulse lasts one cycle. The erase-error bit stays set until a clear command, and chip erase and OTP program never end up suspended. The sequence rules cannot be seen that way and are shown by the bench's scenarios. These cover confirm-address and confirm-code checking, the lock refusals, the busy length under a sweep of lengths, busy time conserved across a suspend, commands refused during suspension, and abort on reset.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_QUERY  = 2'd2,
    MODE_STATUS = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    OP_ERASE  = 3'd0,
    OP_CHIP   = 3'd1,
    OP_PROG   = 3'd2,
    OP_OTP    = 3'd3,
    OP_LOCK   = 3'd4,
    OP_UNLOCK = 3'd5,
    OP_LOCKDN = 3'd6
  } op_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ERASE, PH_CHIP, PH_PROG, PH_OTP, PH_LOCK
  } phase_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_RDSTAT  = 8'h70;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CHIP    = 8'h30;
  localparam logic [7:0] CMD_PROG_A  = 8'h40;
  localparam logic [7:0] CMD_PROG_B  = 8'h10;
  localparam logic [7:0] CMD_OTP     = 8'hC0;
  localparam logic [7:0] CMD_LOCKPFX = 8'h60;
  localparam logic [7:0] CMD_SETLOCK = 8'h01;
  localparam logic [7:0] CMD_LOCKDN  = 8'h2F;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

  function automatic logic timed_kind(op_kind_e k);
    return k inside {OP_ERASE, OP_CHIP, OP_PROG, OP_OTP};
  endfunction
endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    cmd_i,
  input  logic          allow_i,
  input  logic          busy_i,
  input  logic          susp_erase_i,
  input  logic          susp_prog_i,
  input  op_kind_e      run_kind_i,
  output rd_mode_e      mode_o,
  output logic          go_o,
  output op_kind_e      go_kind_o,
  output logic          seq_err_o,
  output logic          lk_erase_o,
  output logic          lk_prog_o,
  output logic          clr_o,
  output logic          susp_req_o,
  output logic          resume_req_o
);
  phase_e        phase_q, phase_d;
  rd_mode_e      mode_q, mode_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          same_addr, any_susp, can_susp;

  assign same_addr = (addr_i == addr_q);
  assign any_susp  = susp_erase_i | susp_prog_i;
  assign can_susp  = (run_kind_i == OP_ERASE) ||
                     ((run_kind_i == OP_PROG) && !susp_erase_i);

  always_comb begin
    phase_d      = phase_q;
    mode_d       = mode_q;
    addr_d       = addr_q;
    go_o         = 1'b0;
    go_kind_o    = OP_ERASE;
    seq_err_o    = 1'b0;
    lk_erase_o   = 1'b0;
    lk_prog_o    = 1'b0;
    clr_o        = 1'b0;
    susp_req_o   = 1'b0;
    resume_req_o = 1'b0;
    if (wr_i && busy_i) begin
      if (cmd_i == CMD_SUSPEND && can_susp) susp_req_o = 1'b1;
    end else if (wr_i) begin
      phase_d = PH_IDLE;
      case (phase_q)
        PH_IDLE: begin
          addr_d = addr_i;
          case (cmd_i)
            CMD_ARRAY:   mode_d = MODE_ARRAY;
            CMD_IDENT:   mode_d = MODE_IDENT;
            CMD_QUERY:   mode_d = MODE_QUERY;
            CMD_RDSTAT:  mode_d = MODE_STATUS;
            CMD_CLRSTAT: clr_o  = 1'b1;
            CMD_ERASE: begin
              mode_d = MODE_STATUS;
              if (any_susp) seq_err_o = 1'b1;
              else          phase_d   = PH_ERASE;
            end
            CMD_CHIP: begin
              mode_d = MODE_STATUS;
              if (any_susp) seq_err_o = 1'b1;
              else          phase_d   = PH_CHIP;
            end
            CMD_PROG_A, CMD_PROG_B: begin
              mode_d = MODE_STATUS;
              if (susp_prog_i) seq_err_o = 1'b1;
              else             phase_d   = PH_PROG;
            end
            CMD_OTP: begin
              mode_d = MODE_STATUS;
              if (any_susp) seq_err_o = 1'b1;
              else          phase_d   = PH_OTP;
            end
            CMD_LOCKPFX: begin
              mode_d  = MODE_STATUS;
              phase_d = PH_LOCK;
            end
            CMD_CONFIRM: begin
              if (any_susp) begin
                resume_req_o = 1'b1;
                mode_d       = MODE_STATUS;
              end
            end
            default: ;
          endcase
        end
        PH_ERASE: begin
          if (!same_addr || cmd_i != CMD_CONFIRM) seq_err_o  = 1'b1;
          else if (!allow_i)                      lk_erase_o = 1'b1;
          else begin go_o = 1'b1; go_kind_o = OP_ERASE; end
        end
        PH_CHIP: begin
          if (!same_addr || cmd_i != CMD_CONFIRM) seq_err_o = 1'b1;
          else begin go_o = 1'b1; go_kind_o = OP_CHIP; end
        end
        PH_PROG: begin
          if (!same_addr)    seq_err_o = 1'b1;
          else if (!allow_i) lk_prog_o = 1'b1;
          else begin go_o = 1'b1; go_kind_o = OP_PROG; end
        end
        PH_OTP: begin
          if (!same_addr) seq_err_o = 1'b1;
          else begin go_o = 1'b1; go_kind_o = OP_OTP; end
        end
        PH_LOCK: begin
          if (!same_addr) seq_err_o = 1'b1;
          else begin
            case (cmd_i)
              CMD_SETLOCK: begin go_o = 1'b1; go_kind_o = OP_LOCK;   end
              CMD_CONFIRM: begin go_o = 1'b1; go_kind_o = OP_UNLOCK; end
              CMD_LOCKDN:  begin go_o = 1'b1; go_kind_o = OP_LOCKDN; end
              default:     seq_err_o = 1'b1;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      mode_q  <= MODE_ARRAY;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      mode_q  <= mode_d;
      addr_q  <= addr_d;
    end
  end

  assign mode_o = busy_i ? MODE_STATUS : mode_q;
endmodule

// File: rtl/fcmd_engine.sv
module fcmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  op_kind_e      go_kind_i,
  input  logic [AW-1:0] go_addr_i,
  input  logic [DW-1:0] go_data_i,
  input  logic          go_err_i,
  input  logic [CW-1:0] len_i,
  input  logic          susp_req_i,
  input  logic          resume_req_i,
  output logic          busy_o,
  output logic          susp_erase_o,
  output logic          susp_prog_o,
  output logic          start_o,
  output op_kind_e      kind_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          done_erase_err_o,
  output logic          done_prog_err_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          run_q, err_q, start_q, se_q, sp_q;
  logic [CW-1:0] cnt_q;
  op_kind_e      kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  // context of the suspended operation
  logic [CW-1:0] sv_cnt_q;
  op_kind_e      sv_kind_q;
  logic [AW-1:0] sv_addr_q;
  logic [DW-1:0] sv_data_q;
  logic          sv_err_q;
  logic          done;

  assign done = run_q && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      err_q     <= 1'b0;
      start_q   <= 1'b0;
      se_q      <= 1'b0;
      sp_q      <= 1'b0;
      cnt_q     <= '0;
      kind_q    <= OP_ERASE;
      addr_q    <= '0;
      data_q    <= '0;
      sv_cnt_q  <= '0;
      sv_kind_q <= OP_ERASE;
      sv_addr_q <= '0;
      sv_data_q <= '0;
      sv_err_q  <= 1'b0;
    end else begin
      start_q <= go_i;
      if (go_i) begin
        kind_q <= go_kind_i;
        addr_q <= go_addr_i;
        data_q <= go_data_i;
        if (timed_kind(go_kind_i)) begin
          run_q <= 1'b1;
          cnt_q <= (len_i == '0) ? ONE : len_i;
          err_q <= go_err_i;
        end
      end else if (run_q) begin
        if (done) begin
          run_q <= 1'b0;
          cnt_q <= '0;
        end else if (susp_req_i) begin
          run_q     <= 1'b0;
          sv_cnt_q  <= cnt_q - ONE;
          sv_kind_q <= kind_q;
          sv_addr_q <= addr_q;
          sv_data_q <= data_q;
          sv_err_q  <= err_q;
          if (kind_q == OP_ERASE) se_q <= 1'b1;
          else                    sp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end else if (resume_req_i) begin
        run_q  <= 1'b1;
        cnt_q  <= sv_cnt_q;
        kind_q <= sv_kind_q;
        addr_q <= sv_addr_q;
        data_q <= sv_data_q;
        err_q  <= sv_err_q;
        se_q   <= 1'b0;
        sp_q   <= 1'b0;
      end
    end
  end

  assign busy_o           = run_q;
  assign susp_erase_o     = se_q;
  assign susp_prog_o      = sp_q;
  assign start_o          = start_q;
  assign kind_o           = kind_q;
  assign addr_o           = addr_q;
  assign data_o           = data_q;
  assign done_erase_err_o = done && err_q && (kind_q inside {OP_ERASE, OP_CHIP});
  assign done_prog_err_o  = done && err_q && (kind_q inside {OP_PROG, OP_OTP});
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       susp_erase_i,
  input  logic       susp_prog_i,
  input  logic       seq_err_i,
  input  logic       lk_erase_i,
  input  logic       lk_prog_i,
  input  logic       done_erase_err_i,
  input  logic       done_prog_err_i,
  input  logic       clr_i,
  output logic [7:0] status_o
);
  logic erase_err_q, prog_err_q, lock_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      erase_err_q <= 1'b0;
      prog_err_q  <= 1'b0;
      lock_err_q  <= 1'b0;
    end else if (clr_i) begin
      erase_err_q <= 1'b0;
      prog_err_q  <= 1'b0;
      lock_err_q  <= 1'b0;
    end else begin
      if (seq_err_i || lk_erase_i || done_erase_err_i) erase_err_q <= 1'b1;
      if (seq_err_i || lk_prog_i || done_prog_err_i)   prog_err_q  <= 1'b1;
      if (lk_erase_i || lk_prog_i)                     lock_err_q  <= 1'b1;
    end
  end

  // flag bits read as zero while busy
  assign status_o = busy_i ? 8'h00 :
                    {1'b1, susp_erase_i, erase_err_q, prog_err_q,
                     1'b0, susp_prog_i, lock_err_q, 1'b0};
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          allow_i,
  input  logic          err_inject_i,
  input  logic [CW-1:0] busy_len_i,
  output logic [1:0]    mode_o,
  output logic [7:0]    status_o,
  output logic          busy_o,
  output logic          op_start_o,
  output logic [2:0]    op_kind_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o
);
  rd_mode_e mode;
  op_kind_e go_kind, run_kind;
  logic go, seq_err, lk_erase, lk_prog, clr, susp_req, resume_req;
  logic busy, susp_erase, susp_prog, de_err, dp_err;

  fcmd_decode #(.AW(AW)) u_decode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .addr_i       (addr_i),
    .cmd_i        (wdata_i[7:0]),
    .allow_i      (allow_i),
    .busy_i       (busy),
    .susp_erase_i (susp_erase),
    .susp_prog_i  (susp_prog),
    .run_kind_i   (run_kind),
    .mode_o       (mode),
    .go_o         (go),
    .go_kind_o    (go_kind),
    .seq_err_o    (seq_err),
    .lk_erase_o   (lk_erase),
    .lk_prog_o    (lk_prog),
    .clr_o        (clr),
    .susp_req_o   (susp_req),
    .resume_req_o (resume_req)
  );

  fcmd_engine #(.AW(AW), .DW(DW), .CW(CW)) u_engine (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .go_i             (go),
    .go_kind_i        (go_kind),
    .go_addr_i        (addr_i),
    .go_data_i        (wdata_i),
    .go_err_i         (err_inject_i),
    .len_i            (busy_len_i),
    .susp_req_i       (susp_req),
    .resume_req_i     (resume_req),
    .busy_o           (busy),
    .susp_erase_o     (susp_erase),
    .susp_prog_o      (susp_prog),
    .start_o          (op_start_o),
    .kind_o           (run_kind),
    .addr_o           (op_addr_o),
    .data_o           (op_data_o),
    .done_erase_err_o (de_err),
    .done_prog_err_o  (dp_err)
  );

  fcmd_status u_status (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .busy_i           (busy),
    .susp_erase_i     (susp_erase),
    .susp_prog_i      (susp_prog),
    .seq_err_i        (seq_err),
    .lk_erase_i       (lk_erase),
    .lk_prog_i        (lk_prog),
    .done_erase_err_i (de_err),
    .done_prog_err_i  (dp_err),
    .clr_i            (clr),
    .status_o         (status_o)
  );

  assign mode_o    = mode;
  assign busy_o    = busy;
  assign op_kind_o = run_kind;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          allow_i,
  input logic          err_inject_i,
  input logic [CW-1:0] busy_len_i,
  input logic [1:0]    mode_o,
  input logic [7:0]    status_o,
  input logic          busy_o,
  input logic          op_start_o,
  input logic [2:0]    op_kind_o,
  input logic [AW-1:0] op_addr_o,
  input logic [DW-1:0] op_data_o
);
  a_r13_busy_reads_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mode_o == 2'd3 && status_o == 8'h00));

  a_r13_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] == 1'b0 && status_o[0] == 1'b0));

  a_r4_ready_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> status_o[7]);

  a_r9_one_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[6] && status_o[2]));

  a_r3_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |=> !op_start_o);

  a_r6_erase_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o) && $past(status_o[5]) &&
     !$past(wr_i && wdata_i[7:0] == 8'h50)) |-> status_o[5]);

  a_r10_no_suspend_chip_otp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (op_kind_o == 3'd1 || op_kind_o == 3'd3)) |=>
      (!status_o[6] && !status_o[2]));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          allow_i = 1'b1;
  logic          err_inject_i = 1'b0;
  logic [CW-1:0] busy_len_i = 8'd4;
  logic [1:0]    mode_o;
  logic [7:0]    status_o;
  logic          busy_o;
  logic          op_start_o;
  logic [2:0]    op_kind_o;
  logic [AW-1:0] op_addr_o;
  logic [DW-1:0] op_data_o;

  int n_chk = 0;
  int n_fail = 0;
  int total_busy = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .allow_i(allow_i), .err_inject_i(err_inject_i),
    .busy_len_i(busy_len_i), .mode_o(mode_o), .status_o(status_o),
    .busy_o(busy_o), .op_start_o(op_start_o), .op_kind_o(op_kind_o),
    .op_addr_o(op_addr_o), .op_data_o(op_data_o)
  );

  // busy cycles, counted at the edge that ends each cycle
  always @(posedge clk) if (busy_o) total_busy <= total_busy + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy_o; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int base, pre;
    logic [AW-1:0] a;
    @(negedge clk); @(negedge clk);
    chk("R1 reset status", status_o, 8'h80);
    chk("R1 reset mode", mode_o, 2'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 post-reset busy", busy_o, 1'b0);
    chk("R1 post-reset status", status_o, 8'h80);

    // R2 mode sweep
    wr(0, 16'h0090); chk("R2 ident", mode_o, 2'd1);
    wr(0, 16'h0098); chk("R2 query", mode_o, 2'd2);
    wr(0, 16'h0070); chk("R2 status", mode_o, 2'd3);
    wr(0, 16'h0033); chk("R2 unknown ignored", mode_o, 2'd3);
    wr(0, 16'h00FF); chk("R2 array", mode_o, 2'd0);

    // R3/R4 erase with length sweep
    for (int len = 0; len <= 7; len++) begin
      a = AW'(21'h8000 * len + 5);
      busy_len_i = CW'(len);
      wr(a, 16'h0020);
      chk("R3 first cycle selects status", mode_o, 2'd3);
      base = total_busy;
      wr(a, 16'h00D0);
      chk("R3 erase start", {op_start_o, op_kind_o}, {1'b1, 3'd0});
      chk("R3 erase addr", op_addr_o, a);
      chk("R13 busy masks status", status_o, 8'h00);
      wait_idle();
      chk("R4 busy length", total_busy - base, (len == 0) ? 1 : len);
      chk("R4 ready", status_o, 8'h80);
    end

    busy_len_i = 8'd3;
    wr(21'h100, 16'h0030); wr(21'h100, 16'h00D0);
    chk("R3 chip kind", {op_start_o, op_kind_o}, {1'b1, 3'd1});
    wait_idle();
    wr(21'h200, 16'h0040); wr(21'h200, 16'hBEEF);
    chk("R3 prog 40h", {op_start_o, op_kind_o, op_data_o}, {1'b1, 3'd2, 16'hBEEF});
    wait_idle();
    wr(21'h201, 16'h0010); wr(21'h201, 16'h1234);
    chk("R3 prog 10h", {op_start_o, op_kind_o, op_data_o}, {1'b1, 3'd2, 16'h1234});
    wait_idle();
    wr(21'h82, 16'h00C0); wr(21'h82, 16'h5A5A);
    chk("R3 otp", {op_start_o, op_kind_o, op_data_o}, {1'b1, 3'd3, 16'h5A5A});
    wait_idle();
    chk("R3 otp done", status_o, 8'h80);

    // R5 sequence errors
    wr(21'h10, 16'h0020); wr(21'h11, 16'h00D0);
    chk("R5 addr mismatch", {op_start_o, busy_o, status_o}, {2'b00, 8'hB0});
    wr(0, 16'h0050); chk("R6 clear", status_o, 8'h80);
    wr(21'h10, 16'h0020); wr(21'h10, 16'h00FF);
    chk("R5 bad confirm", {op_start_o, status_o}, {1'b0, 8'hB0});
    wr(0, 16'h0090); chk("R5 back to idle", mode_o, 2'd1);
    wr(21'h20, 16'h0040); wr(21'h21, 16'h0001);
    chk("R5 prog addr mismatch", {op_start_o, status_o}, {1'b0, 8'hB0});
    wr(0, 16'h0050);

    // R7 lock refusal
    allow_i = 1'b0;
    wr(21'h30, 16'h0020); wr(21'h30, 16'h00D0);
    chk("R7 erase locked", {op_start_o, busy_o, status_o}, {2'b00, 8'hA2});
    wr(0, 16'h0050); chk("R6 clear lock bit", status_o, 8'h80);
    wr(21'h30, 16'h0040); wr(21'h30, 16'h0077);
    chk("R7 prog locked", {op_start_o, status_o}, {1'b0, 8'h92});
    wr(0, 16'h0050);
    wr(21'h30, 16'h0030); wr(21'h30, 16'h00D0);
    chk("R7 chip ignores allow", {op_start_o, busy_o}, 2'b11);
    wait_idle();
    allow_i = 1'b1;

    // R8 injected errors, R6 stickiness
    err_inject_i = 1'b1;
    wr(21'h40, 16'h0020); wr(21'h40, 16'h00D0);
    err_inject_i = 1'b0;
    wait_idle();
    chk("R8 erase error", status_o, 8'hA0);
    wr(21'h41, 16'h0040); wr(21'h41, 16'h0001);
    wait_idle();
    chk("R6 sticky after good op", status_o, 8'hA0);
    wr(0, 16'h0050); chk("R6 cleared", status_o, 8'h80);
    err_inject_i = 1'b1;
    wr(21'h42, 16'h00C0); wr(21'h42, 16'h0001);
    err_inject_i = 1'b0;
    wait_idle();
    chk("R8 otp error", status_o, 8'h90);
    wr(0, 16'h0050);

    // R13 writes ignored while busy
    busy_len_i = 8'd10;
    wr(21'h50, 16'h0020); wr(21'h50, 16'h00D0);
    wr(0, 16'h00FF);
    chk("R13 busy mode", mode_o, 2'd3);
    wr(0, 16'h0050);
    wait_idle();
    chk("R13 FF ignored while busy", mode_o, 2'd3);

    // R9 erase suspend, nested program, R11 refusals
    busy_len_i = 8'd20;
    base = total_busy;
    wr(21'h60, 16'h0020); wr(21'h60, 16'h00D0);
    repeat (4) @(negedge clk);
    wr(21'h60, 16'h00B0);
    pre = total_busy - base;
    chk("R9 erase suspended", {busy_o, status_o}, {1'b0, 8'hC0});
    busy_len_i = 8'd6;
    wr(21'h70, 16'h0040); wr(21'h70, 16'h00AA);
    chk("R11 prog under erase suspend", {op_start_o, op_kind_o}, {1'b1, 3'd2});
    wr(21'h70, 16'h00B0);
    chk("R10 nested prog not suspendable", busy_o, 1'b1);
    wait_idle();
    chk("R9 erase still suspended", status_o, 8'hC0);
    wr(21'h71, 16'h00C0);
    chk("R11 otp refused", status_o, 8'hF0);
    wr(0, 16'h0050); chk("R6 clear keeps suspend", status_o, 8'hC0);
    wr(21'h72, 16'h0020);
    chk("R11 erase refused", status_o, 8'hF0);
    wr(0, 16'h0050);
    base = total_busy;
    wr(21'h60, 16'h00D0);
    chk("R9 resumed", {busy_o, op_kind_o}, {1'b1, 3'd0});
    wait_idle();
    chk("R9 busy conserved", pre + total_busy - base, 20);
    chk("R9 erase done", status_o, 8'h80);

    // R9 program suspend
    busy_len_i = 8'd10;
    base = total_busy;
    wr(21'h80, 16'h0010); wr(21'h80, 16'h0F0F);
    repeat (2) @(negedge clk);
    wr(21'h80, 16'h00B0);
    pre = total_busy - base;
    chk("R9 prog suspended", status_o, 8'h84);
    wr(21'h80, 16'h0040);
    chk("R11 prog refused under prog suspend", status_o, 8'hB4);
    wr(0, 16'h0050);
    base = total_busy;
    wr(21'h80, 16'h00D0);
    wait_idle();
    chk("R9 prog busy conserved", pre + total_busy - base, 10);
    chk("R9 prog resumed data", {op_kind_o, op_data_o, status_o}, {3'd2, 16'h0F0F, 8'h80});

    // R10 chip erase and otp not suspendable
    busy_len_i = 8'd8;
    base = total_busy;
    wr(21'h90, 16'h0030); wr(21'h90, 16'h00D0);
    wr(21'h90, 16'h00B0);
    chk("R10 chip ignores suspend", busy_o, 1'b1);
    wait_idle();
    chk("R10 chip length", {total_busy - base, status_o}, {32'd8, 8'h80});
    wr(21'h84, 16'h00C0); wr(21'h84, 16'h0003);
    wr(21'h84, 16'h00B0);
    chk("R10 otp ignores suspend", busy_o, 1'b1);
    wait_idle();
    chk("R10 otp done", status_o, 8'h80);

    // R12 lock commands
    allow_i = 1'b0;
    wr(21'hA0, 16'h0060); wr(21'hA0, 16'h0001);
    chk("R12 set lock", {op_start_o, op_kind_o, busy_o}, {1'b1, 3'd4, 1'b0});
    wr(21'hA0, 16'h0060); wr(21'hA0, 16'h00D0);
    chk("R12 unlock", {op_start_o, op_kind_o}, {1'b1, 3'd5});
    wr(21'hA0, 16'h0060); wr(21'hA0, 16'h002F);
    chk("R12 lock-down", {op_start_o, op_kind_o, status_o}, {1'b1, 3'd6, 8'h80});
    wr(21'hA0, 16'h0060); wr(21'hA0, 16'h0055);
    chk("R12 bad lock code", {op_start_o, status_o}, {1'b0, 8'hB0});
    wr(0, 16'h0050);
    allow_i = 1'b1;

    // R1 reset aborts
    busy_len_i = 8'd50;
    wr(21'hB0, 16'h0020); wr(21'hB0, 16'h00D0);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 abort", {busy_o, mode_o, status_o}, {1'b0, 2'd0, 8'h80});
    rst_ni = 1'b1;
    wr(21'hB0, 16'h0020); wr(21'hB0, 16'h00D0);
    wr(21'hB0, 16'h00B0);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 suspend cleared", {busy_o, status_o}, {1'b0, 8'h80});

    finish_run();
  end
endmodule